// File: doc/BRIEF.md
# Edge-Selectable Wake-Up Interrupt Port

This block watches a group of asynchronous input pins (eight by default), brings each one into the clock domain, and looks for a transition on it. For each pin, software chooses whether a rising or a falling transition counts. A transition of the chosen kind sets a per-pin pending flag. The flag stays set until software clears it by writing a one to it. All pins share one interrupt request and one service routine.

The enabled pending flags are ORed into a wake-up request, which brings the processor out of a halt or idle state. The same OR, gated by a single global interrupt enable, forms the interrupt request. With the global enable off, a pin can still wake the processor, and execution then continues without an interrupt being taken. No separate global pending flag exists: the pending register itself is the status that software reads.

Software uses a small register interface with a two-bit address, a write strobe and a combinational read port.

Top module: `edge_wake_port`

## Requirements
- R1: After reset, the enable, polarity, pending and global-enable registers read 0, and irq_o and wake_o are low. A pin level that is already present when reset is released sets no pending bit.
- R2: With polarity bit 0 (rising), a 0-to-1 transition on a pin sets its pending bit (address 2), visible after the third rising clock edge that follows the change. A 1-to-0 transition sets nothing.
- R3: With polarity bit 1 (falling), a 1-to-0 transition sets the pending bit and a 0-to-1 transition does not. Rewriting a polarity bit while the pin is held steady sets no pending bit.
- R4: A pending bit stays set until software writes a 1 to that bit position at address 2. Writing a 0 to a position leaves that bit unchanged.
- R5: When a qualifying transition and a write-one-to-clear reach the same pending bit in the same clock cycle, the bit remains set.
- R6: A pending bit is recorded even while its enable bit (address 0) is 0. It drives neither wake_o nor irq_o until its enable bit is set.
- R7: wake_o is high whenever any bit of (pending AND enable) is 1, whatever the value of the global enable.
- R8: irq_o equals the global enable (address 3, bit 0) ANDed with wake_o.
- R9: Register map: address 0 is the per-pin enable, address 1 the per-pin polarity (1 means falling), address 2 the pending flags (write-one-to-clear), and address 3 bit 0 the global interrupt enable. Addresses 0, 1 and 3 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Asynchronous pin inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address, used for both read and write |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wake-up request from halt or idle |

## Verification
A pin change applied between two clock edges passes through two synchronizer flops and one history flop. The pending bit it sets therefore first reads back after the third rising edge. The bench drives pins on falling edges and samples on the falling edge that follows that third rising edge. It also checks the falling edge one cycle earlier and expects the bit still clear there. A register write takes effect at the rising edge that samples the strobe, and the bench reads the result on the next falling edge. irq_o and wake_o follow the registers with no further delay. For the clear-versus-transition collision, the bench places the clear strobe exactly on the third rising edge after the pin change.

// File: rtl/edge_wake_pkg.sv
package edge_wake_pkg;
  localparam logic [1:0] ADDR_ENABLE   = 2'd0;
  localparam logic [1:0] ADDR_POLARITY = 2'd1;
  localparam logic [1:0] ADDR_PENDING  = 2'd2;
  localparam logic [1:0] ADDR_GLOBAL   = 2'd3;
endpackage

// File: rtl/ewp_sync.sv
module ewp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ewp_edge.sv
module ewp_edge #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] falling_sel,
  output logic [W-1:0] prev,
  output logic [W-1:0] hit
);
  // Edge detection is held off until both the synchronizer and the
  // history flop hold pin samples taken after reset.
  localparam int ARM_LEN = STAGES + 1;
  logic [ARM_LEN-1:0] arm_q;
  logic [W-1:0]       prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm_q  <= '0;
      prev_q <= '0;
    end else begin
      arm_q  <= {arm_q[ARM_LEN-2:0], 1'b1};
      prev_q <= cur;
    end

  // Only a real transition counts: a polarity change alone never matches.
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
        if (falling_sel[i]) hit[i] = arm_q[ARM_LEN-1] &  prev_q[i] & ~cur[i];
        else                hit[i] = arm_q[ARM_LEN-1] & ~prev_q[i] &  cur[i];
      end
    end
  endgenerate

  assign prev = prev_q;
endmodule

// File: rtl/ewp_pend.sv
module ewp_pend #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] pend_q;

  // A transition wins over a clear that arrives in the same cycle.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | hit;

  assign pend = pend_q;
endmodule

// File: rtl/ewp_regs.sv
module ewp_regs
  import edge_wake_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pend,
  output logic [W-1:0] enable,
  output logic [W-1:0] falling_sel,
  output logic         gie,
  output logic [W-1:0] clr,
  output logic [W-1:0] rdata
);
  logic [W-1:0] en_q, pol_q;
  logic         gie_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
      gie_q <= 1'b0;
    end else if (wr) begin
      case (addr)
        ADDR_ENABLE:   en_q  <= wdata;
        ADDR_POLARITY: pol_q <= wdata;
        ADDR_GLOBAL:   gie_q <= wdata[0];
        default: ;
      endcase
    end

  assign clr = (wr && addr == ADDR_PENDING) ? wdata : '0;

  always_comb begin
    case (addr)
      ADDR_ENABLE:   rdata = en_q;
      ADDR_POLARITY: rdata = pol_q;
      ADDR_PENDING:  rdata = pend;
      default:       rdata = {{(W-1){1'b0}}, gie_q};
    endcase
  end

  assign enable      = en_q;
  assign falling_sel = pol_q;
  assign gie         = gie_q;
endmodule

// File: rtl/edge_wake_port.sv
module edge_wake_port #(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  output logic             irq_o,
  output logic             wake_o
);
  logic [NPINS-1:0] sync_q, prev_q, hit, pend, enable, falling_sel, clr;
  logic             gie;

  ewp_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pins_i), .q(sync_q));

  ewp_edge #(.W(NPINS), .STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst_n(rst_n), .cur(sync_q), .falling_sel(falling_sel),
    .prev(prev_q), .hit(hit));

  ewp_pend #(.W(NPINS)) pend_i (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .pend(pend));

  ewp_regs #(.W(NPINS)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .pend(pend), .enable(enable),
    .falling_sel(falling_sel), .gie(gie), .clr(clr), .rdata(reg_rdata));

  assign wake_o = |(pend & enable);
  assign irq_o  = gie & wake_o;
endmodule

// File: rtl/edge_wake_port_chk.sv
module edge_wake_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         wake,
  input logic [W-1:0] pend,
  input logic [W-1:0] clr,
  input logic [W-1:0] cur,
  input logic [W-1:0] prev
);
  // R4: a set pending bit survives unless a clear addressed it
  p_pend_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));

  // R2/R3: a newly set pending bit needs a synchronized transition on that pin
  p_new_pend_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend & ~$past(pend)) & ~($past(cur) ^ $past(prev))) == '0));

  // R7: wake only with something pending
  p_wake_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (pend != '0));

  // R8: the interrupt never fires without a wake condition
  p_irq_implies_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);
endmodule

bind edge_wake_port edge_wake_port_chk #(.W(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq_o), .wake(wake_o), .pend(pend),
  .clr(clr), .cur(sync_q), .prev(prev_q));

// File: tb/edge_wake_port_tb_top.sv
module edge_wake_port_tb_top;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pins = '0, wdata = '0, rdata;
  logic wr = 1'b0, irq, wake;
  logic [1:0] addr = 2'd0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edge_wake_port #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .wake_o(wake));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called on a falling edge; returns on the next falling edge
  task automatic wreg(input logic [1:0] a, input logic [N-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [N-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    pins = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(6);
    // R1: reset state, pins held at levels during reset set nothing
    for (int a = 0; a < 4; a++) begin
      rreg(a[1:0], v); chk($sformatf("R1 reg %0d after reset", a), v, '0);
    end
    chk("R1 irq/wake after reset", {6'b0, irq, wake}, '0);
    pins = '0; idle(4);
    wreg(2'd2, '1);

    // R9: readback
    wreg(2'd0, 8'h3C); rreg(2'd0, v); chk("R9 enable readback", v, 8'h3C);
    wreg(2'd1, 8'hC3); rreg(2'd1, v); chk("R9 polarity readback", v, 8'hC3);
    wreg(2'd3, 8'hFF); rreg(2'd3, v); chk("R9 global readback", v, 8'h01);
    wreg(2'd0, '1);

    // R2/R3 sweep: polarity x pin x direction
    for (int pol = 0; pol < 2; pol++) begin
      wreg(2'd1, pol ? '1 : '0);
      for (int i = 0; i < N; i++) begin
        for (int dir = 0; dir < 2; dir++) begin  // dir 0 rising, 1 falling
          logic [N-1:0] exp;
          string tag;
          pins[i] = dir[0]; idle(5);
          wreg(2'd2, '1); idle(1);
          exp = ((dir == 0 && pol == 0) || (dir == 1 && pol == 1)) ? (N'(1) << i) : '0;
          tag = pol ? "R3" : "R2";
          pins[i] = ~dir[0];
          @(posedge clk); @(posedge clk); @(negedge clk);
          rreg(2'd2, v); chk($sformatf("%s pin %0d dir %0d early", tag, i, dir), v, '0);
          @(posedge clk); @(negedge clk);
          rreg(2'd2, v); chk($sformatf("%s pin %0d dir %0d", tag, i, dir), v, exp);
          chk($sformatf("R8 irq pin %0d", i), {7'b0, irq}, {7'b0, |exp});
          pins[i] = 1'b0; idle(5);
          wreg(2'd2, '1);
        end
      end
    end

    // R3: polarity rewrite with a steady pin
    wreg(2'd1, '0); pins = 8'h10; idle(5); wreg(2'd2, '1);
    wreg(2'd1, 8'h10); idle(5);
    rreg(2'd2, v); chk("R3 polarity change to falling, steady pin", v, '0);
    wreg(2'd1, 8'h00); idle(5);
    rreg(2'd2, v); chk("R3 polarity change to rising, steady pin", v, '0);
    pins = '0; idle(5); wreg(2'd2, '1);

    // R6/R7/R8: record while disabled, then enable
    wreg(2'd0, '0); wreg(2'd3, 8'h01);
    pins[3] = 1'b1; idle(5);
    rreg(2'd2, v); chk("R6 pending recorded while disabled", v, 8'h08);
    chk("R6 no wake/irq while disabled", {6'b0, irq, wake}, '0);
    wreg(2'd3, 8'h00); wreg(2'd0, 8'h08);
    chk("R7 wake with global enable off", {7'b0, wake}, 8'h01);
    chk("R8 irq low with global enable off", {7'b0, irq}, '0);
    wreg(2'd3, 8'h01);
    chk("R8 irq with global enable on", {7'b0, irq}, 8'h01);

    // R4: write zero keeps, write one clears
    wreg(2'd2, 8'hF7); rreg(2'd2, v); chk("R4 write of zeros keeps bit", v, 8'h08);
    wreg(2'd2, 8'h08); rreg(2'd2, v); chk("R4 write one clears bit", v, '0);
    chk("R7 wake drops after clear", {7'b0, wake}, '0);

    // R5: clear and new edge in the same cycle
    pins = 8'h00; idle(5);
    pins[5] = 1'b1; idle(5);
    pins[2] = 1'b1; idle(5);
    rreg(2'd2, v); chk("R5 setup", v, 8'h24);
    pins[2] = 1'b0; idle(5);
    pins[2] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wreg(2'd2, 8'h24);
    rreg(2'd2, v); chk("R5 edge wins over simultaneous clear", v, 8'h04);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule